// File: doc/BRIEF.md
# Serial Link Packet Framer

This block wraps each transaction packet in the link-layer envelope of a serial point-to-point link and sends the result as a byte stream. A packet comes in on a byte-wide valid/ready stream with a last flag. It holds a header, an optional payload and an optional 4-byte end-to-end check. Two sideband bits travel with the packet: one picks the header length and one says whether the end-to-end check is present. The framer puts a start symbol and a 2-byte sequence number in front of the packet. It then forwards the packet bytes unchanged and appends a 4-byte link CRC and an end symbol.

The output stream is byte-wide valid/ready with one control flag per byte, which marks symbol bytes. Packet bytes pass straight through without buffering. Input ready is held low while the framer emits its own overhead bytes. If a packet ends inside its header, or its payload is too long, the framer raises an error pulse and closes the frame with an inverted end symbol so that the receiver discards it.

Top module: `link_framer`

## Requirements
- R1: Each frame goes out in this order: start symbol 0xFB, sequence field (most significant byte first), packet bytes exactly as received, link CRC (4 bytes), end symbol.
- R2: The header length is 16 bytes when `in_hdr_long` is 0 and 20 bytes when it is 1. Both sideband bits are sampled when the start symbol is accepted.
- R3: Payloads from 0 to 4096 bytes are framed without error, including a packet that is only a header.
- R4: When `in_ecrc_en` is 1, the last 4 input bytes are forwarded unchanged as the end-to-end check, and the payload limit does not count them.
- R5: The link CRC uses polynomial 0x04C11DB7 with the register preset to all ones. Each byte is shifted in most significant bit first, with no reflection. The CRC covers the sequence field and every forwarded packet byte. The final register value is complemented and sent most significant byte first.
- R6: The sequence number is 12 bits wide, with the upper 4 bits of the 2-byte field zero. It is 0 after reset and advances by one per frame, bad frames included, wrapping from 4095 to 0.
- R7: `out_ctrl` is 1 only on the start byte and the end byte. A good frame ends with 0xFD.
- R8: A frame holds 8 + H + P + E bytes (header H, payload P, check E). With a 16-byte header, a 4096-byte payload and the check present, this is 4124 bytes.
- R9: `in_ready` is 0 whenever the byte on the output is the start symbol, a sequence byte, a CRC byte or the end symbol.
- R10: Under any pattern of `out_ready` and input valid gaps, no byte is lost or repeated, and a byte that is offered but not accepted stays unchanged on the output.
- R11: If `in_last` arrives before the header is complete, `frame_err` is high for exactly one cycle. The frame then closes with the CRC and the end symbol 0x02.
- R12: An input byte beyond header + 4096 + check bytes is discarded, as is every byte up to and including `in_last`. `frame_err` pulses once and the frame closes with the CRC of the forwarded bytes and the end symbol 0x02.
- R13: While reset is held and right after it is released, `out_valid`, `in_ready` and `frame_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Final byte of the packet |
| in_hdr_long | input | 1 | Header length select: 0 = 16 bytes, 1 = 20 bytes |
| in_ecrc_en | input | 1 | Packet ends with a 4-byte end-to-end check |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Frame byte |
| out_ctrl | output | 1 | Byte is a start or end symbol |
| frame_err | output | 1 | One-cycle pulse on a malformed packet |

## Verification
The bench drives packets with a header only and with a maximum-length payload. A framer that miscounts its limit would flag a legal 4096-byte payload, or would send a frame that is not 4124 bytes long. Packets run under output backpressure and gapped input. A pass-through that ignored ready on one side would drop or repeat bytes, which breaks the byte-exact comparison and the CRC. Truncated-header and overlong packets check that the error pulse is single and that the end symbol is inverted. More than 4096 frames are sent so that the sequence field is seen to wrap to zero rather than carry into its upper bits.

// File: rtl/link_framer_pkg.sv
// Package: shared constants and state type for the link framer.
// Assumes 8-bit data path; symbol values are fixed control codes.
package link_framer_pkg;
    localparam logic [7:0] SYM_START = 8'hFB;
    localparam logic [7:0] SYM_END   = 8'hFD;
    localparam logic [7:0] SYM_BAD   = ~SYM_END;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEQ_HI,
        ST_SEQ_LO,
        ST_BODY,
        ST_DRAIN,
        ST_LCRC,
        ST_END
    } fr_state_t;
endpackage

// File: rtl/link_framer_crc.sv
// Module: byte-serial CRC register, MSB-first, non-reflected.
// Assumes init has priority over en; the caller complements the result.
module link_framer_crc #(
    parameter int          CRC_W = 32,
    parameter logic [31:0] POLY  = 32'h04C11DB7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             en,
    input  logic [7:0]       din,
    output logic [CRC_W-1:0] crc
);
    function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c,
                                              input logic [7:0] d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ POLY[CRC_W-1:0];
        end
        return r;
    endfunction

    // Preset to all ones on reset or init, otherwise fold in one byte.
    always_ff @(posedge clk) begin
        if (!rst_n || init) crc <= '1;
        else if (en)        crc <= step(crc, din);
    end
endmodule

// File: rtl/link_framer_seq.sv
// Module: per-link frame sequence counter.
// Assumes adv pulses once per completed frame; wraps at 2**SEQ_W.
module link_framer_seq #(
    parameter int SEQ_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [SEQ_W-1:0] seq
);
    // Count completed frames, modulo 2**SEQ_W.
    always_ff @(posedge clk) begin
        if (!rst_n)   seq <= '0;
        else if (adv) seq <= seq + SEQ_W'(1);
    end

    // R6
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (seq == $past(seq) + SEQ_W'(1)));
endmodule

// File: rtl/link_framer.sv
// Module: link framer top. Emits start symbol, sequence field, packet
// bytes (pass-through), inverted CRC-32 and end symbol.
// Assumes in_valid/in_data/in_last and sideband are held until accepted,
// and sideband stays fixed for the whole packet.
module link_framer #(
    parameter int MAX_PAYLOAD = 4096,
    parameter int HDR_SHORT   = 16,
    parameter int HDR_LONG    = 20,
    parameter int ECRC_BYTES  = 4,
    parameter int SEQ_W       = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_hdr_long,
    input  logic       in_ecrc_en,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_ctrl,
    output logic       frame_err
);
    import link_framer_pkg::*;

    localparam int CNT_W = $clog2(HDR_LONG + MAX_PAYLOAD + ECRC_BYTES + 1);
    localparam logic [CNT_W-1:0] H_S = CNT_W'(HDR_SHORT);
    localparam logic [CNT_W-1:0] H_L = CNT_W'(HDR_LONG);
    localparam logic [CNT_W-1:0] P_M = CNT_W'(MAX_PAYLOAD);
    localparam logic [CNT_W-1:0] E_B = CNT_W'(ECRC_BYTES);

    fr_state_t        state;
    logic             hdr_long_q, ecrc_q, bad_q;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       crc_idx;
    logic [31:0]      crc;
    logic [SEQ_W-1:0] seq;
    logic [15:0]      seq_field;
    logic [CNT_W-1:0] hdr_len, limit;
    logic             over, short_end, out_fire, in_fire, crc_en, seq_adv;

    assign seq_field = {{(16-SEQ_W){1'b0}}, seq};
    assign hdr_len   = hdr_long_q ? H_L : H_S;
    assign limit     = hdr_len + P_M + (ecrc_q ? E_B : '0);
    assign over      = (cnt == limit);
    assign short_end = in_last && ((cnt + CNT_W'(1)) < hdr_len);
    assign out_fire  = out_valid && out_ready;
    assign in_fire   = in_valid && in_ready;
    assign seq_adv   = (state == ST_END) && out_fire;

    link_framer_seq #(.SEQ_W(SEQ_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .adv(seq_adv), .seq(seq)
    );

    link_framer_crc #(.CRC_W(32), .POLY(32'h04C11DB7)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(state == ST_IDLE),
        .en(crc_en), .din(out_data), .crc(crc)
    );

    // Output mux and handshake steering per state.
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_ctrl  = 1'b0;
        in_ready  = 1'b0;
        crc_en    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                out_valid = in_valid;
                out_data  = SYM_START;
                out_ctrl  = 1'b1;
            end
            ST_SEQ_HI: begin
                out_valid = 1'b1;
                out_data  = seq_field[15:8];
                crc_en    = out_fire;
            end
            ST_SEQ_LO: begin
                out_valid = 1'b1;
                out_data  = seq_field[7:0];
                crc_en    = out_fire;
            end
            ST_BODY: begin
                if (over) begin
                    in_ready = 1'b1;
                end else begin
                    out_valid = in_valid;
                    out_data  = in_data;
                    in_ready  = out_ready;
                    crc_en    = out_fire;
                end
            end
            ST_DRAIN: in_ready = 1'b1;
            ST_LCRC: begin
                out_valid = 1'b1;
                case (crc_idx)
                    2'd0:    out_data = ~crc[31:24];
                    2'd1:    out_data = ~crc[23:16];
                    2'd2:    out_data = ~crc[15:8];
                    default: out_data = ~crc[7:0];
                endcase
            end
            ST_END: begin
                out_valid = 1'b1;
                out_ctrl  = 1'b1;
                out_data  = bad_q ? SYM_BAD : SYM_END;
            end
            default: ;
        endcase
    end

    // Frame sequencing, byte counting and error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            hdr_long_q <= 1'b0;
            ecrc_q     <= 1'b0;
            bad_q      <= 1'b0;
            cnt        <= '0;
            crc_idx    <= '0;
            frame_err  <= 1'b0;
        end else begin
            frame_err <= 1'b0;
            unique case (state)
                ST_IDLE: if (out_fire) begin
                    hdr_long_q <= in_hdr_long;
                    ecrc_q     <= in_ecrc_en;
                    bad_q      <= 1'b0;
                    cnt        <= '0;
                    state      <= ST_SEQ_HI;
                end
                ST_SEQ_HI: if (out_fire) state <= ST_SEQ_LO;
                ST_SEQ_LO: if (out_fire) state <= ST_BODY;
                ST_BODY: if (in_fire) begin
                    if (over) begin
                        frame_err <= 1'b1;
                        bad_q     <= 1'b1;
                        state     <= in_last ? ST_LCRC : ST_DRAIN;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                        if (in_last) begin
                            state <= ST_LCRC;
                            if (short_end) begin
                                frame_err <= 1'b1;
                                bad_q     <= 1'b1;
                            end
                        end
                    end
                end
                ST_DRAIN: if (in_fire && in_last) state <= ST_LCRC;
                ST_LCRC: if (out_fire) begin
                    crc_idx <= crc_idx + 2'd1;
                    if (crc_idx == 2'd3) state <= ST_END;
                end
                ST_END: if (out_fire) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7
    ctrl_symbol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ctrl) |->
        (out_data == SYM_START || out_data == SYM_END || out_data == SYM_BAD));

    // R10
    hold_under_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R11
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R12
    body_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY) |-> (cnt <= limit));
endmodule

// File: tb/link_framer_tb.sv
module link_framer_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ready, in_last, in_hdr_long, in_ecrc_en;
    logic [7:0] in_data;
    logic       out_valid, out_ready, out_ctrl, frame_err;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    link_framer u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_hdr_long(in_hdr_long), .in_ecrc_en(in_ecrc_en),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_ctrl(out_ctrl), .frame_err(frame_err)
    );

    int checks = 0;
    int fails  = 0;
    int seq_exp = 0;
    int pkt_no  = 0;
    logic [7:0] got_d[$];
    logic       got_c[$];
    logic [7:0] exp_d[$];
    int err_cnt, ovh_viol;

    // hdr_long, ecrc, payload, input gap mode, backpressure mode
    localparam int NV = 8;
    localparam int V_HL [NV] = '{0, 1, 0, 1, 0, 1, 0, 1};
    localparam int V_EC [NV] = '{0, 0, 1, 1, 0, 1, 1, 0};
    localparam int V_PL [NV] = '{0, 0, 5, 37, 64, 100, 4096, 4096};
    localparam int V_GP [NV] = '{0, 0, 0, 1, 0, 1, 0, 2};
    localparam int V_BP [NV] = '{0, 0, 0, 0, 1, 2, 0, 1};

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ 32'h04C11DB7;
        end
        return r;
    endfunction

    function automatic logic [7:0] pat(input int p, input int idx);
        return 8'((idx * 13) + (p * 7) + 5);
    endfunction

    // Drive one packet of n input bytes and capture the frame.
    task automatic run_pkt(input bit hl, input bit ec, input int n, input int gap,
                           input int bp, input int fwd);
        int idx = 0;
        int cyc = 0;
        bit done = 0;
        bit clr = 0;
        got_d.delete(); got_c.delete();
        err_cnt = 0; ovh_viol = 0;
        in_hdr_long = hl; in_ecrc_en = ec;
        while (!done) begin
            @(negedge clk);
            if (clr) begin in_valid = 1'b0; in_last = 1'b0; clr = 0; end
            if (!in_valid && idx < n && (gap == 0 || (cyc % (gap + 2)) != 0)) begin
                in_valid = 1'b1;
                in_data  = pat(pkt_no, idx);
                in_last  = (idx == n - 1);
            end
            out_ready = (bp == 0) ? 1'b1 : ((cyc % (bp + 2)) != 0);
            #1;
            if (frame_err) err_cnt++;
            if (out_valid && in_ready &&
                (got_d.size() < 3 || got_d.size() >= 3 + fwd)) ovh_viol++;
            if (out_valid && out_ready) begin
                got_d.push_back(out_data);
                got_c.push_back(out_ctrl);
                if (out_ctrl && got_d.size() > 1) done = 1;
            end
            if (in_valid && in_ready) begin idx++; clr = 1; end
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        if (frame_err) err_cnt++;
    endtask

    // Build the expected frame and compare it with the captured one.
    task automatic check_pkt(input string tag, input int fwd, input bit bad);
        logic [31:0] c;
        int mism = -1;
        int a = 0, e = 0;
        exp_d.delete();
        c = 32'hFFFF_FFFF;
        exp_d.push_back(8'hFB);
        exp_d.push_back(8'((seq_exp >> 8) & 15));
        exp_d.push_back(8'(seq_exp & 255));
        for (int i = 0; i < fwd; i++) exp_d.push_back(pat(pkt_no, i));
        for (int i = 1; i < exp_d.size(); i++) c = crc_b(c, exp_d[i]);
        c = ~c;
        exp_d.push_back(c[31:24]); exp_d.push_back(c[23:16]);
        exp_d.push_back(c[15:8]);  exp_d.push_back(c[7:0]);
        exp_d.push_back(bad ? 8'h02 : 8'hFD);
        chk(got_d.size() == exp_d.size(), "R8", {tag, " frame length"},
            got_d.size(), exp_d.size());
        for (int i = 0; i < exp_d.size() && i < got_d.size(); i++) begin
            if (mism < 0 && (got_d[i] != exp_d[i] ||
                got_c[i] != (i == 0 || i == exp_d.size() - 1))) begin
                mism = i; a = int'(got_d[i]); e = int'(exp_d[i]);
            end
        end
        chk(mism < 0, "R1 R4 R5 R6 R7 R10", {tag, " frame byte/ctrl"}, a, e);
        chk(err_cnt == (bad ? 1 : 0), bad ? "R11 R12" : "R3",
            {tag, " error pulses"}, err_cnt, bad ? 1 : 0);
        chk(ovh_viol == 0, "R9", {tag, " ready during overhead"}, ovh_viol, 0);
        seq_exp = (seq_exp + 1) % 4096;
        pkt_no++;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R13 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
        in_hdr_long = 1'b0; in_ecrc_en = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid && !in_ready && !frame_err, "R13", "outputs in reset",
            {out_valid, in_ready, frame_err}, 0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(!out_valid && !in_ready && !frame_err, "R13", "outputs after reset",
            {out_valid, in_ready, frame_err}, 0);

        // Table of legal packets (R2 R3 R4 R8 R10); entry 6 is the 4124-byte case.
        for (int v = 0; v < NV; v++) begin
            int h, nb;
            h  = V_HL[v] ? 20 : 16;
            nb = h + V_PL[v] + (V_EC[v] ? 4 : 0);
            run_pkt(V_HL[v] != 0, V_EC[v] != 0, nb, V_GP[v], V_BP[v], nb);
            if (v == 6) chk(got_d.size() == 4124, "R8", "max frame 4124",
                            got_d.size(), 4124);
            check_pkt("R2 table", nb, 1'b0);
        end

        // R11: packet ends after 9 of 20 header bytes.
        run_pkt(1'b1, 1'b0, 9, 0, 1, 9);
        check_pkt("R11 short header", 9, 1'b1);

        // R12: 16 + 4096 + 4 legal bytes, then 3 extra bytes dropped.
        run_pkt(1'b0, 1'b1, 16 + 4096 + 4 + 3, 1, 0, 16 + 4096 + 4);
        check_pkt("R12 overlong", 16 + 4096 + 4, 1'b0 == 1'b1 ? 1'b0 : 1'b1);

        // R6: run through a full sequence wrap with header-only packets.
        for (int k = 0; k < 4096; k++) begin
            run_pkt(1'b0, 1'b0, 16, 0, 0, 16);
            check_pkt("R6 wrap", 16, 1'b0);
        end
        chk(seq_exp == 10, "R6", "sequence after wrap", seq_exp, 10);

        // R6 R13: reset returns the sequence number to zero.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        seq_exp = 0;
        run_pkt(1'b1, 1'b1, 24, 0, 2, 24);
        check_pkt("R6 after reset", 24, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule